// File: doc/BRIEF.md
# Configurable receive FIFO controller

This block keeps the bookkeeping for a circular receive queue whose storage sits in a shared, word-addressed message RAM. A 32-bit configuration word sets four things: the queue's word base address, its element count, a watermark fill level and the behaviour when the queue is full. A producer raises `push` for one cycle per incoming element. The block answers in the same cycle with a RAM write strobe and the word address of the slot to fill. A consumer reads the element at `get_addr` and acknowledges it with `pop_ack`.

Each element takes a fixed number of RAM words, set by a parameter. The block reports the fill level, both indices and a full indication. It also keeps two sticky interrupt flags, one for watermark reached and one for message lost, and software clears each by writing 1 to its clear input. The RAM, the element contents and the bus fabric are outside the block.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: The configuration word resets to 0. Its fields are: bit 31 full-mode (0 blocking, 1 overwrite), bits 30:24 watermark, bits 22:16 size and bits 15:0 word base address. `cfg_rdata` returns the written word with bit 23 and bits 1:0 forced to 0.
- R2: The slot address is base + index × ELEM_WORDS (default 4), computed modulo 2^16, with bits 1:0 of the base taken as 0. `ram_waddr` uses the put index and `get_addr` uses the get index.
- R3: A `push` into a non-full queue of nonzero size raises `ram_we` in the same cycle. After the clock edge the put index has advanced and `fill_level` has risen by one.
- R4: `pop_ack` on a non-empty queue advances the get index and lowers the level by one. On an empty queue it has no effect. A push and a pop in the same cycle leave the level unchanged.
- R5: Both indices wrap from size−1 back to 0.
- R6: In blocking mode, a push into a full queue with no pop in the same cycle is dropped. `ram_we` stays low, the indices and level do not change, and `lost_irq` is set. A push into a full queue together with a pop is accepted.
- R7: In overwrite mode, a push into a full queue writes the slot of the oldest element. Both indices advance and the level stays at size.
- R8: With a size field of 0, every push is rejected and sets `lost_irq`. A size field above 64 acts as 64.
- R9: `wm_irq` is set on the edge at which the level becomes equal to a watermark in 1..64 from a different value. A watermark of 0 or above 64 never sets it. The flag is sticky until `clr_wm` is pulsed, and a set in the same cycle wins over the clear.
- R10: A configuration write resets both indices and the level to 0. A push or pop in the same cycle is ignored.
- R11: `full` is high exactly when the size is nonzero and the level equals the effective size. The level never exceeds the effective size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| push | input | 1 | An incoming element is offered |
| pop_ack | input | 1 | The oldest element has been consumed |
| clr_wm | input | 1 | Write-1 clear of the watermark flag |
| clr_lost | input | 1 | Write-1 clear of the message-lost flag |
| ram_we | output | 1 | RAM write strobe for the offered element |
| ram_waddr | output | 16 | RAM word address of the put slot |
| get_addr | output | 16 | RAM word address of the oldest element |
| put_idx | output | 6 | Put index |
| get_idx | output | 6 | Get index |
| fill_level | output | 7 | Number of stored elements |
| full | output | 1 | Queue full |
| wm_irq | output | 1 | Sticky watermark flag |
| lost_irq | output | 1 | Sticky message-lost flag |

## Verification
A wrong index or a missed wrap shows up as a wrong address in the very cycle that uses it. A write goes to a slot other than the expected one, and the scoreboard compare on the next pop of that element then fails. A level that is off by one changes `full` and the accept decision at the next full boundary, and it moves the watermark edge by one cycle. The bench tracks every index and flag after each edge, so any divergence is reported within one clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADDR_W = 16;
  localparam int FLD_W  = 7;

  typedef struct packed {
    logic              ovr;
    logic [FLD_W-1:0]  wm;
    logic              rsvd;
    logic [FLD_W-1:0]  size;
    logic [ADDR_W-1:0] base;
  } cfg_word_t;
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
#(
  parameter int MAX_ELEMS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              ovr_mode,
  output logic              wm_en,
  output logic [FLD_W-1:0]  wm_lvl,
  output logic [FLD_W-1:0]  eff_size,
  output logic [ADDR_W-1:0] base_addr
);
  localparam logic [FLD_W-1:0] CAP = FLD_W'(MAX_ELEMS);

  cfg_word_t cfg_q, cfg_in;

  always_comb begin
    cfg_in           = cfg_word_t'(cfg_wdata);
    cfg_in.rsvd      = 1'b0;
    cfg_in.base[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_in;
  end

  assign cfg_rdata = cfg_q;
  assign ovr_mode  = cfg_q.ovr;
  assign wm_lvl    = cfg_q.wm;
  assign wm_en     = (cfg_q.wm != '0) && (cfg_q.wm <= CAP);
  assign eff_size  = (cfg_q.size > CAP) ? CAP : cfg_q.size;
  assign base_addr = cfg_q.base;

  // R1: the size field follows a write on the next cycle
  assert_size_written_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[22:16] == $past(cfg_wdata[22:16]));
  // R8: the effective size never exceeds the capacity
  assert_size_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    eff_size <= CAP);
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int MAX_ELEMS = 64,
  parameter int IDX_W     = $clog2(MAX_ELEMS),
  parameter int LVL_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             push,
  input  logic             pop,
  input  logic             ovr_mode,
  input  logic [FLD_W-1:0] eff_size,
  output logic             accept,
  output logic             drop,
  output logic [IDX_W-1:0] put_q,
  output logic [IDX_W-1:0] get_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [LVL_W-1:0] lvl_nxt,
  output logic             full
);
  logic [LVL_W-1:0] n_elems;
  logic             empty, do_pop, ovr_push, live;

  assign n_elems = LVL_W'(eff_size);
  assign live    = (n_elems != '0);
  assign empty   = (lvl_q == '0);
  assign full    = live && (lvl_q == n_elems);
  assign do_pop  = pop && !empty && !cfg_we;
  assign accept  = push && !cfg_we && live && (!full || ovr_mode || do_pop);
  assign drop    = push && !cfg_we && !accept;
  assign ovr_push = accept && full && !do_pop;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i,
                                            input logic [LVL_W-1:0] n);
    return ((LVL_W'(i) + LVL_W'(1)) >= n) ? '0 : i + IDX_W'(1);
  endfunction

  always_comb begin
    if (cfg_we)                         lvl_nxt = '0;
    else if (accept && !full && !do_pop) lvl_nxt = lvl_q + LVL_W'(1);
    else if (do_pop && !accept)          lvl_nxt = lvl_q - LVL_W'(1);
    else                                 lvl_nxt = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_we) begin
      put_q <= '0;
      get_q <= '0;
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_nxt;
      if (accept)             put_q <= bump(put_q, n_elems);
      if (do_pop || ovr_push) get_q <= bump(get_q, n_elems);
    end
  end

  // R11: level bounded by effective size
  assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= n_elems);
  // R5: put index stays inside the ring
  assert_put_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    live |-> LVL_W'(put_q) < n_elems);
  // R6: a blocked push leaves the state untouched
  assert_block_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !ovr_mode && !pop && !cfg_we) |=> $stable(lvl_q) && $stable(put_q));
  // R7: overwrite keeps the level at size
  assert_ovr_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full && ovr_mode && !cfg_we) |=> lvl_q == $past(lvl_q));
  // R10: configuration write clears the ring state
  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (lvl_q == '0) && (put_q == '0) && (get_q == '0));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drop,
  input  logic             wm_en,
  input  logic [FLD_W-1:0] wm_lvl,
  input  logic [LVL_W-1:0] lvl_q,
  input  logic [LVL_W-1:0] lvl_nxt,
  input  logic             clr_wm,
  input  logic             clr_lost,
  output logic             wm_flag,
  output logic             lost_flag
);
  logic             wm_hit;
  logic [LVL_W-1:0] wm_cmp;

  assign wm_cmp = LVL_W'(wm_lvl);
  assign wm_hit = wm_en && (lvl_nxt == wm_cmp) && (lvl_q != wm_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_flag   <= 1'b0;
      lost_flag <= 1'b0;
    end else begin
      wm_flag   <= wm_hit | (wm_flag & ~clr_wm);
      lost_flag <= drop | (lost_flag & ~clr_lost);
    end
  end

  // R6 / R8: a rejected element always raises the lost flag
  assert_lost_set_R6: assert property (@(posedge clk) disable iff (rst)
    drop |=> lost_flag);
  // R9: a disabled watermark never raises the flag
  assert_wm_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!wm_en && !wm_flag) |=> !wm_flag);
  // R9: flags are sticky without a clear
  assert_wm_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (wm_flag && !clr_wm) |=> wm_flag);
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rxq_pkg::*;
#(
  parameter int MAX_ELEMS  = 64,
  parameter int ELEM_WORDS = 4,
  localparam int IDX_W     = $clog2(MAX_ELEMS),
  localparam int LVL_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              push,
  input  logic              pop_ack,
  input  logic              clr_wm,
  input  logic              clr_lost,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [ADDR_W-1:0] get_addr,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [LVL_W-1:0]  fill_level,
  output logic              full,
  output logic              wm_irq,
  output logic              lost_irq
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ELEM_WORDS);

  logic              ovr_mode, wm_en, accept, drop;
  logic [FLD_W-1:0]  wm_lvl, eff_size;
  logic [ADDR_W-1:0] base_addr;
  logic [LVL_W-1:0]  lvl_nxt;

  rxq_cfg #(.MAX_ELEMS(MAX_ELEMS)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ovr_mode(ovr_mode), .wm_en(wm_en),
    .wm_lvl(wm_lvl), .eff_size(eff_size), .base_addr(base_addr)
  );

  rxq_ptrs #(.MAX_ELEMS(MAX_ELEMS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_ptrs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .push(push), .pop(pop_ack),
    .ovr_mode(ovr_mode), .eff_size(eff_size), .accept(accept), .drop(drop),
    .put_q(put_idx), .get_q(get_idx), .lvl_q(fill_level), .lvl_nxt(lvl_nxt),
    .full(full)
  );

  rxq_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst(rst), .drop(drop), .wm_en(wm_en), .wm_lvl(wm_lvl),
    .lvl_q(fill_level), .lvl_nxt(lvl_nxt), .clr_wm(clr_wm),
    .clr_lost(clr_lost), .wm_flag(wm_irq), .lost_flag(lost_irq)
  );

  assign ram_we    = accept;
  assign ram_waddr = base_addr + ADDR_W'(put_idx) * STRIDE;
  assign get_addr  = base_addr + ADDR_W'(get_idx) * STRIDE;

  // R3: a write strobe never occurs with a zero-size queue
  assert_we_live_R3: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> eff_size != '0);
  // R4: a pop on an empty queue leaves the get index alone
  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_ack && fill_level == '0 && !push && !cfg_we) |=> $stable(get_idx));
endmodule

// File: tb/test_rx_fifo_ctrl.sv
module test_rx_fifo_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, cfg_we, push, pop_ack, clr_wm, clr_lost;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        ram_we, full, wm_irq, lost_irq;
  logic [15:0] ram_waddr, get_addr;
  logic [5:0]  put_idx, get_idx;
  logic [6:0]  fill_level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side model
  int  m_size, m_lvl, m_put, m_get, m_wm;
  bit  m_ovr, m_wmen, m_wmf, m_lost;
  int  m_base;
  int  ram[int];
  int  sb[$];
  int  next_data = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_ctrl i_rx_fifo_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .push(push), .pop_ack(pop_ack), .clr_wm(clr_wm),
    .clr_lost(clr_lost), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .get_addr(get_addr), .put_idx(put_idx), .get_idx(get_idx),
    .fill_level(fill_level), .full(full), .wm_irq(wm_irq), .lost_irq(lost_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_state();
    chk(fill_level == m_lvl, "R3/R4 level", fill_level, m_lvl);
    chk(put_idx == m_put, "R5 put index", put_idx, m_put);
    chk(get_idx == m_get, "R5 get index", get_idx, m_get);
    chk(full == (m_size != 0 && m_lvl == m_size), "R11 full", full,
        (m_size != 0 && m_lvl == m_size));
    chk(wm_irq == m_wmf, "R9 watermark flag", wm_irq, m_wmf);
    chk(lost_irq == m_lost, "R6/R8 lost flag", lost_irq, m_lost);
  endtask

  function automatic int wrap(input int i);
    return (i + 1 >= m_size) ? 0 : i + 1;
  endfunction

  // driver + monitor for one cycle of traffic
  task automatic step(input bit p, input bit q);
    bit mfull, mpop, macc;
    int nl, exp_a, got;
    @(negedge clk);
    check_state();
    cfg_we = 0; clr_wm = 0; clr_lost = 0;
    push = p; pop_ack = q;
    #1;
    mfull = (m_size != 0) && (m_lvl == m_size);
    mpop  = q && (m_lvl != 0);
    macc  = p && (m_size != 0) && (!mfull || m_ovr || mpop);
    chk(ram_we == macc, "R3/R6/R8 write strobe", ram_we, macc);
    if (mpop) begin
      exp_a = (m_base + m_get * 4) & 16'hFFFF;
      chk(get_addr == exp_a, "R2 get address", get_addr, exp_a);
      got = ram.exists(int'(get_addr)) ? ram[int'(get_addr)] : -1;
      chk(got == sb[0], "R4 scoreboard data", got, sb[0]);
      void'(sb.pop_front());
    end
    if (macc) begin
      exp_a = (m_base + m_put * 4) & 16'hFFFF;
      chk(ram_waddr == exp_a, "R2 put address", ram_waddr, exp_a);
      if (mfull && !mpop) void'(sb.pop_front());
      ram[int'(ram_waddr)] = next_data;
      sb.push_back(next_data);
      next_data++;
    end
    @(posedge clk);
    nl = m_lvl;
    if (macc && !mfull && !mpop) nl = m_lvl + 1;
    else if (mpop && !macc)      nl = m_lvl - 1;
    if (m_wmen && nl == m_wm && m_lvl != m_wm) m_wmf = 1;
    if (p && !macc) m_lost = 1;
    if (macc) m_put = wrap(m_put);
    if (mpop || (macc && mfull && !mpop)) m_get = wrap(m_get);
    m_lvl = nl;
  endtask

  task automatic write_cfg(input logic [31:0] w, input logic [31:0] exp_rb,
                           input bit p);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = w; push = p; pop_ack = p;
    clr_wm = 0; clr_lost = 0;
    @(posedge clk);
    m_ovr  = w[31];
    m_wm   = int'(w[30:24]);
    m_wmen = (m_wm != 0) && (m_wm <= 64);
    m_size = (int'(w[22:16]) > 64) ? 64 : int'(w[22:16]);
    m_base = int'({w[15:2], 2'b00});
    m_lvl = 0; m_put = 0; m_get = 0;
    sb.delete();
    @(negedge clk);
    cfg_we = 0; push = 0; pop_ack = 0;
    chk(cfg_rdata == exp_rb, "R1 readback", cfg_rdata, exp_rb);
    chk(fill_level == 0 && put_idx == 0 && get_idx == 0 && !ram_we,
        "R10 cfg write clears ring", fill_level, 0);
  endtask

  task automatic clear_flags(input bit w, input bit l);
    @(negedge clk);
    push = 0; pop_ack = 0; clr_wm = w; clr_lost = l;
    @(posedge clk);
    if (w) m_wmf = 0;
    if (l) m_lost = 0;
    @(negedge clk);
    clr_wm = 0; clr_lost = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_wdata = 0; push = 0; pop_ack = 0;
    clr_wm = 0; clr_lost = 0;
    m_size = 0; m_lvl = 0; m_put = 0; m_get = 0; m_wm = 0; m_base = 0;
    m_ovr = 0; m_wmen = 0; m_wmf = 0; m_lost = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk(cfg_rdata == 0, "R1 reset config", cfg_rdata, 0);
    check_state();

    // R8: size 0 rejects everything
    step(1, 0);
    step(0, 0);
    clear_flags(0, 1);

    // blocking, watermark 3, size 5, base 0x0103 -> 0x0100
    write_cfg(32'h0305_0103, 32'h0305_0100, 0);
    for (int i = 0; i < 5; i++) step(1, 0);   // R3, R9 at level 3
    step(0, 0);                               // R11 full
    step(1, 0);                               // R6 drop
    step(0, 0);
    step(1, 1);                               // R6 push with pop at full accepted
    step(0, 1); step(0, 1);
    clear_flags(1, 1);
    step(1, 0); step(1, 0);                   // R5 wrap
    for (int i = 0; i < 6; i++) step(0, 1);   // R4 drain, last one on empty
    step(0, 1);                               // R4 pop on empty ignored
    step(0, 0);
    for (int i = 0; i < 3; i++) step(1, 0);   // R9 reaches 3 again
    step(0, 0);
    write_cfg(32'h0305_0100, 32'h0305_0100, 1); // R10 push/pop ignored
    step(0, 0);

    // overwrite, watermark 0, size 0x7F -> 64, bit 23 set
    write_cfg(32'h80FF_2002, 32'h807F_2000, 0);
    for (int i = 0; i < 67; i++) step(1, 0);  // R7, R8 clamp
    step(0, 0);
    for (int i = 0; i < 64; i++) step(0, 1);
    step(0, 0);

    // blocking, watermark 70 (disabled), size 3
    write_cfg(32'h4603_0000, 32'h4603_0000, 0);
    for (int i = 0; i < 4; i++) step(1, 0);   // R9 off, R6 drop
    step(1, 1);
    for (int i = 0; i < 3; i++) step(0, 1);
    step(0, 0);
    clear_flags(1, 1);
    step(0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule